// File: doc/BRIEF.md
# Dual-Modulus Pulse Swallow Frequency Divider

This block divides a fast input clock by a programmable ratio of 64·N + A. It does not use one wide counter for this. A prescaler stage divides by 65 or by 64. A swallow counter keeps the prescaler in its divide-by-65 mode for the first A prescaler periods of each output cycle. A programmable counter ends the output cycle after N prescaler periods. The result is A periods of 65 clocks and N−A periods of 64 clocks, which gives 64·N + A input clocks between two output pulses.

The two setting words are captured into a staged ratio register when the load strobe is high on a clock edge. A setting is rejected if N is below 5 or if A is not strictly smaller than N. A rejected setting raises the error flag and leaves the staged ratio unchanged. The counters take the staged values only at an output cycle boundary, so a cycle that is running always ends with the ratio it started with. A load captured on the same edge as a cycle boundary first applies at the boundary after that one.

Top module: `pulse_swallow_div`

## Requirements
- R1: The spacing between two consecutive rising edges of `fp` is exactly 64·N + A input clocks, where N and A are the active settings.
- R2: `fp` is high for exactly one input clock per output cycle.
- R3: With A = 0 the prescaler divides by 64 in every period, so the spacing is exactly 64·N.
- R4: The edge settings are honoured exactly: N = 5 with A = 4 gives 324, and N = 64 with A = 63 gives 4159.
- R5: A load with N < 5 sets `cfg_err` to 1 on the next clock, and the previous valid ratio stays in force.
- R6: A load with A ≥ N (for example N = 20, A = 20) sets `cfg_err` to 1, and the previous valid ratio stays in force.
- R7: A valid load clears `cfg_err` on the next clock. `cfg_err` changes only on clocks where `load` is high.
- R8: A load captured in the middle of an output cycle does not change that cycle's length. It takes effect from the next cycle boundary.
- R9: During reset and right after it, `fp` and `cfg_err` are 0. After reset the ratio is A = 0, N = 5, and the first `fp` comes 320 clocks after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Input clock to be divided |
| rst_n | input | 1 | Synchronous active-low reset |
| a_set | input | 6 | Swallow count A (0 to 63) |
| n_set | input | 12 | Programmable count N (5 to 4095) |
| load | input | 1 | Captures a_set and n_set into the staged ratio |
| fp | output | 1 | One-clock pulse at the end of each output cycle |
| cfg_err | output | 1 | High after a rejected load, low after an accepted load |

## Verification
The ratio is measured between consecutive `fp` pulses under several kinds of setting:
- A = 0 settings show whether the divide-by-64 path works by itself.
- Small nonzero A values show whether the swallow periods add exactly one clock each.
- The A = N−1 and A = 63 settings show whether the mode switch happens on the right prescaler period, since an off-by-one swallow changes the count by one.
- Rejected settings are each followed by a period measurement, which shows whether the old ratio survived.

A load placed in the middle of a cycle separates deferred application of the new ratio from immediate application.

// File: rtl/psd_pkg.sv
// Shared constants and types for the pulse swallow divider.
// Assumes: the prescaler base modulus is a power of two matching the swallow width.
package psd_pkg;
    localparam int PSD_A_W   = 6;
    localparam int PSD_N_W   = 12;
    localparam int PSD_PRE_M = 64;
    localparam int PSD_N_MIN = 5;

    // Prescaler modulus selection
    typedef enum logic {
        MOD_BASE = 1'b0,   // divide by M
        MOD_PLUS = 1'b1    // divide by M+1
    } psd_mode_t;
endpackage

// File: rtl/psd_cfg.sv
// Staged ratio register with validation.
// Captures the setting words on load when N >= N_MIN and A < N.
// Otherwise it keeps the old ratio and flags an error.
// Assumes: N_W > A_W.
module psd_cfg #(
    parameter int A_W   = 6,
    parameter int N_W   = 12,
    parameter int N_MIN = 5,
    parameter int RST_A = 0,
    parameter int RST_N = 5
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load,
    input  logic [A_W-1:0] a_in,
    input  logic [N_W-1:0] n_in,
    output logic [A_W-1:0] a_cfg,
    output logic [N_W-1:0] n_cfg,
    output logic           cfg_err
);
    localparam int PAD_W = N_W - A_W;

    logic setting_ok;

    // Decide whether the offered pair forms a legal ratio
    always_comb begin
        setting_ok = (n_in >= N_W'(N_MIN)) && ({{PAD_W{1'b0}}, a_in} < n_in);
    end

    // Update staged ratio and error flag on each load
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_cfg   <= A_W'(RST_A);
            n_cfg   <= N_W'(RST_N);
            cfg_err <= 1'b0;
        end else if (load) begin
            cfg_err <= !setting_ok;
            if (setting_ok) begin
                a_cfg <= a_in;
                n_cfg <= n_in;
            end
        end
    end
endmodule

// File: rtl/psd_prescaler.sv
// Synchronous dual-modulus prescaler.
// Counts input clocks and flags the last clock of each period: M clocks in base mode, M+1 in plus mode.
// Assumes: mode is stable for a whole prescaler period.
module psd_prescaler
    import psd_pkg::*;
#(
    parameter int PRE_M = 64
) (
    input  logic      clk,
    input  logic      rst_n,
    input  psd_mode_t mode,
    output logic      pre_tc
);
    localparam int CNT_W = $clog2(PRE_M + 1);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] last;

    // Last count value of the current period
    always_comb begin
        last   = (mode == MOD_PLUS) ? CNT_W'(PRE_M) : CNT_W'(PRE_M - 1);
        pre_tc = (cnt == last);
    end

    // Advance the period counter and wrap on terminal count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (pre_tc) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + CNT_W'(1);
        end
    end
endmodule

// File: rtl/psd_counters.sv
// Swallow and programmable counters.
// They count prescaler periods, pick the prescaler modulus, reload from the staged ratio at the end of
// each output cycle and emit the output pulse.
// Assumes: staged ratio satisfies A < N and N >= 1.
module psd_counters
    import psd_pkg::*;
#(
    parameter int A_W   = 6,
    parameter int N_W   = 12,
    parameter int RST_A = 0,
    parameter int RST_N = 5
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           pre_tc,
    input  logic [A_W-1:0] a_cfg,
    input  logic [N_W-1:0] n_cfg,
    output psd_mode_t      mode,
    output logic           fp,
    output logic [A_W-1:0] sw_rem,
    output logic [N_W-1:0] pc_rem
);
    logic cycle_end;

    // Select modulus from swallow state and detect the final period
    always_comb begin
        mode      = (sw_rem != '0) ? MOD_PLUS : MOD_BASE;
        cycle_end = pre_tc && (pc_rem == N_W'(1));
    end

    // Count down prescaler periods and reload at the cycle boundary
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sw_rem <= A_W'(RST_A);
            pc_rem <= N_W'(RST_N);
        end else if (cycle_end) begin
            sw_rem <= a_cfg;
            pc_rem <= n_cfg;
        end else if (pre_tc) begin
            pc_rem <= pc_rem - N_W'(1);
            if (sw_rem != '0) begin
                sw_rem <= sw_rem - A_W'(1);
            end
        end
    end

    // Register the one-clock output pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fp <= 1'b0;
        end else begin
            fp <= cycle_end;
        end
    end
endmodule

// File: rtl/pulse_swallow_div.sv
// Pulse swallow divider top level.
// Divides clk_in by 64*N + A through a 64/65 prescaler steered by a swallow counter.
// Assumes: a synchronous reset and settings loaded on clock edges.
module pulse_swallow_div
    import psd_pkg::*;
#(
    parameter int A_W   = PSD_A_W,
    parameter int N_W   = PSD_N_W,
    parameter int PRE_M = PSD_PRE_M,
    parameter int N_MIN = PSD_N_MIN,
    parameter int RST_A = 0,
    parameter int RST_N = PSD_N_MIN
) (
    input  logic           clk_in,
    input  logic           rst_n,
    input  logic [A_W-1:0] a_set,
    input  logic [N_W-1:0] n_set,
    input  logic           load,
    output logic           fp,
    output logic           cfg_err
);
    logic [A_W-1:0] a_cfg;
    logic [N_W-1:0] n_cfg;
    logic [A_W-1:0] sw_rem;
    logic [N_W-1:0] pc_rem;
    logic           pre_tc;
    psd_mode_t      mode;

    psd_cfg #(
        .A_W(A_W), .N_W(N_W), .N_MIN(N_MIN), .RST_A(RST_A), .RST_N(RST_N)
    ) u_cfg (
        .clk(clk_in), .rst_n(rst_n), .load(load), .a_in(a_set), .n_in(n_set),
        .a_cfg(a_cfg), .n_cfg(n_cfg), .cfg_err(cfg_err)
    );

    psd_prescaler #(
        .PRE_M(PRE_M)
    ) u_pre (
        .clk(clk_in), .rst_n(rst_n), .mode(mode), .pre_tc(pre_tc)
    );

    psd_counters #(
        .A_W(A_W), .N_W(N_W), .RST_A(RST_A), .RST_N(RST_N)
    ) u_cnt (
        .clk(clk_in), .rst_n(rst_n), .pre_tc(pre_tc), .a_cfg(a_cfg), .n_cfg(n_cfg),
        .mode(mode), .fp(fp), .sw_rem(sw_rem), .pc_rem(pc_rem)
    );
endmodule

// File: rtl/psd_chk.sv
// Property checker for the pulse swallow divider, bound to the top module.
// Assumes: the top level exposes staged ratio and counter state by name.
module psd_chk #(
    parameter int A_W   = 6,
    parameter int N_W   = 12,
    parameter int N_MIN = 5
) (
    input logic           clk,
    input logic           rst_n,
    input logic           load,
    input logic           fp,
    input logic           cfg_err,
    input logic [A_W-1:0] a_cfg,
    input logic [N_W-1:0] n_cfg,
    input logic [A_W-1:0] sw_rem,
    input logic [N_W-1:0] pc_rem
);
    // R2
    fp_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fp |=> !fp);

    // R7
    err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(cfg_err));

    // R6
    staged_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (n_cfg >= N_W'(N_MIN)) && ({{(N_W-A_W){1'b0}}, a_cfg} < n_cfg));

    // R1
    swallow_within_chk: assert property (@(posedge clk) disable iff (!rst_n)
        {{(N_W-A_W){1'b0}}, sw_rem} < pc_rem);
endmodule

bind pulse_swallow_div psd_chk #(
    .A_W(A_W), .N_W(N_W), .N_MIN(N_MIN)
) u_chk (
    .clk(clk_in), .rst_n(rst_n), .load(load), .fp(fp), .cfg_err(cfg_err),
    .a_cfg(a_cfg), .n_cfg(n_cfg), .sw_rem(sw_rem), .pc_rem(pc_rem)
);

// File: tb/pulse_swallow_div_bench.sv
module pulse_swallow_div_bench;
    logic        clk_in = 1'b0;
    logic        rst_n  = 1'b0;
    logic [5:0]  a_set  = '0;
    logic [11:0] n_set  = 12'd5;
    logic        load   = 1'b0;
    logic        fp;
    logic        cfg_err;

    int unsigned n_tests = 0;
    int unsigned n_fail  = 0;
    int unsigned cyc     = 0;
    int unsigned cur_ratio;

    always #2.5 clk_in = ~clk_in;

    pulse_swallow_div u_pulse_swallow_div (
        .clk_in(clk_in), .rst_n(rst_n), .a_set(a_set), .n_set(n_set),
        .load(load), .fp(fp), .cfg_err(cfg_err)
    );

    // Each vector holds a, n, expected error and the requirement tag number.
    localparam int NV = 11;
    localparam int VEC [NV][4] = '{
        '{0,   5,  0, 3},
        '{4,   5,  0, 4},
        '{1,   6,  0, 1},
        '{19,  20, 0, 1},
        '{20,  20, 1, 6},
        '{0,   64, 0, 3},
        '{63,  64, 0, 4},
        '{0,   4,  1, 5},
        '{10,  100,0, 7},
        '{30,  12, 1, 6},
        '{7,   2,  1, 5}
    };

    always @(negedge clk_in) cyc <= cyc + 1;

    task automatic check(input string tag, input int unsigned act, input int unsigned exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Return negedge count at the next sampled fp pulse
    task automatic wait_fp(output int unsigned t);
        do @(negedge clk_in); while (!fp);
        t = cyc;
    endtask

    task automatic do_load(input int a, input int n);
        @(negedge clk_in);
        a_set = 6'(a);
        n_set = 12'(n);
        load  = 1'b1;
        @(negedge clk_in);
        load  = 1'b0;
    endtask

    initial begin
        #1000000;
        n_fail++;
        n_tests++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int unsigned t0, t1, t2, width;
        // R9 reset state
        repeat (4) @(negedge clk_in);
        check("R9 fp in reset", fp, 0);
        check("R9 cfg_err in reset", cfg_err, 0);
        rst_n = 1'b1;
        t0 = cyc + 1;
        @(negedge clk_in);
        check("R9 fp after reset", fp, 0);
        wait_fp(t1);
        check("R9 first period", t1 - t0 + 1, 320);
        cur_ratio = 320;

        // R2 pulse width
        width = 0;
        while (fp) begin width++; @(negedge clk_in); end
        check("R2 fp width", width, 1);

        // Table walk: R1 R3 R4 R5 R6 R7
        for (int i = 0; i < NV; i++) begin
            do_load(VEC[i][0], VEC[i][1]);
            check($sformatf("R%0d cfg_err vec %0d", VEC[i][3], i), cfg_err, VEC[i][2]);
            if (VEC[i][2] == 0) cur_ratio = 64 * VEC[i][1] + VEC[i][0];
            wait_fp(t0);
            wait_fp(t1);
            check($sformatf("R%0d ratio vec %0d", VEC[i][3], i), t1 - t0, cur_ratio);
        end

        // R8 mid-cycle load: current cycle keeps old ratio (6410), next uses new
        wait_fp(t0);
        repeat (10) @(negedge clk_in);
        do_load(2, 7);
        wait_fp(t1);
        wait_fp(t2);
        check("R8 current cycle unchanged", t1 - t0, cur_ratio);
        check("R8 next cycle new ratio", t2 - t1, 450);
        cur_ratio = 450;

        // R5 rejected load then R7 valid load clears flag
        do_load(0, 3);
        check("R5 cfg_err set", cfg_err, 1);
        repeat (20) @(negedge clk_in);
        check("R7 cfg_err held without load", cfg_err, 1);
        wait_fp(t0);
        wait_fp(t1);
        check("R5 ratio kept", t1 - t0, 450);
        do_load(1, 5);
        check("R7 cfg_err cleared", cfg_err, 0);
        wait_fp(t0);
        wait_fp(t1);
        check("R1 ratio 321", t1 - t0, 321);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule